// File: doc/BRIEF.md
# Set-Associative Read-Only Word Cache with Exact LRU

This block sits between a requester and a slower backing memory and keeps recently read 32-bit words close at hand. The requester presents a byte address. The block answers from its own storage when it can. Otherwise it fetches the word through a simple request/acknowledge memory port, stores it, and then answers. Every response carries a flag that tells a hit from a miss. Running hit and miss totals are exported.

The storage is split into `SETS` sets of `WAYS` ways, and each line holds one word. With `WAYS = 1` the block is direct-mapped. With `SETS = 1` it is fully associative. Replacement is exact least-recently-used inside the addressed set. It is based on a stamp that each way takes from a global count of accepted requests.

The controller is a two-state machine:
- `ST_IDLE` accepts a request and does the lookup in the same cycle. Transition *idle→idle* on a hit or with no request. Transition *idle→fetch* on a miss.
- `ST_FETCH` holds the memory request until the acknowledge arrives. Transition *fetch→idle* on the acknowledge, which installs the word and answers the requester. Transition *fetch→fetch* while it waits.

Top module: `wordcache_lru`

## Requirements
- R1: Address bits [1:0] are ignored for lookup. Two byte addresses that differ only in those bits refer to the same cached word.
- R2: The set is (addr >> 2) mod SETS, taken from addr bits just above the byte offset. The tag is all address bits above the set field, and only the tag is compared. The default geometry is 8 sets by 4 ways with a 64-bit address: set at addr[4:2], tag at addr[63:5].
- R3: A hit needs a way in the addressed set that is valid and holds an equal tag. After reset no way is valid, so the first access to any address misses, including address 0. At most one way of a set ever matches.
- R4: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. On a hit, `rsp_valid` is high in the next cycle with `rsp_hit` = 1 and the stored word on `rsp_data`, and `req_ready` stays high.
- R5: On a miss, `mem_req` rises in the cycle after acceptance with `mem_addr` equal to the request address with bits [1:0] cleared. Both hold steady and `req_ready` stays low until `mem_ack`. In the cycle after the acknowledge, `rsp_valid` is high with `rsp_hit` = 0 and `rsp_data` equal to the acknowledged `mem_data`.
- R6: A miss fills an invalid way of the addressed set if one exists, taking the lowest-numbered invalid way.
- R7: If every way of the set is valid, the miss evicts the way with the smallest stamp. On equal stamps the lowest way index is evicted.
- R8: A reference counter advances by one on every accepted request. The n-th request since reset writes stamp n into the way it hits or fills. For example, with stamps 12, 7, 20, 15 in a full set, a miss on reference 21 evicts way 1, which then holds stamp 21.
- R9: `hit_count` and `miss_count` each rise by exactly one when a hit or miss response is given. Whenever the block is idle, their sum equals the number of accepted requests.
- R10: Synchronous reset `rst` invalidates every way, zeroes both counts and the reference counter, drops `rsp_valid` and `mem_req`, and leaves the block idle.
- R11: With 4 entries and word addresses 0, 4, 0, 4, a direct-mapped build (4 sets, 1 way) misses all four times. A 2-set, 2-way build hits on the third and fourth access. A 1-set, 4-way build also hits on those two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the requested word |
| req_ready | output | 1 | Block can accept a request (idle) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | 1 = served from storage, 0 = fetched |
| mem_req | output | 1 | Backing-memory read request |
| mem_addr | output | ADDR_W | Word-aligned address for the memory read |
| mem_ack | input | 1 | Memory acknowledge, data valid this cycle |
| mem_data | input | DATA_W | Word returned by memory |
| hit_count | output | CNT_W | Responses given as hits |
| miss_count | output | CNT_W | Responses given as misses |

## Verification
A hit answers on the first clock edge after acceptance. A miss raises `mem_req` after that same edge and answers one edge after `mem_ack`. The bench's memory model acknowledges on the falling edge after it sees the request, so a miss response comes two edges after acceptance. The bench samples on falling edges and requires each response exactly one falling edge after acceptance for a hit and exactly two for a miss, so any lost or extra cycle is reported. The counts are compared only while all instances are idle, which is the only time their sum is defined to equal the number of requests.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } wc_state_e;
endpackage

// File: rtl/wc_way_match.sv
module wc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 59,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && row_valid[w] && (row_tag[w] == look_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/wc_victim_pick.sv
module wc_victim_pick #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 32,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WAYS-1:0]            row_valid,
    input  logic [WAYS-1:0][CNT_W-1:0] row_stamp,
    output logic [WAY_W-1:0]           victim
);
    logic             found_free;
    logic [CNT_W-1:0] oldest;

    always_comb begin
        victim     = '0;
        found_free = 1'b0;
        oldest     = row_stamp[0];
        // empty ways first, lowest index wins
        for (int w = 0; w < WAYS; w++) begin
            if (!found_free && !row_valid[w]) begin
                found_free = 1'b1;
                victim     = WAY_W'(w);
            end
        end
        // otherwise the strictly smallest stamp, ties kept at the lower index
        if (!found_free) begin
            for (int w = 1; w < WAYS; w++) begin
                if (row_stamp[w] < oldest) begin
                    oldest = row_stamp[w];
                    victim = WAY_W'(w);
                end
            end
        end
    end

    assert_victim_free_R6: assert property (@(posedge clk) disable iff (rst)
        (!(&row_valid)) |-> !row_valid[victim]);
endmodule

// File: rtl/wordcache_lru.sv
module wordcache_lru
    import wc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int IDX_BITS = $clog2(SETS);
    localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W    = ADDR_W - 2 - IDX_BITS;

    wc_state_e state_q, state_d;

    logic              valid_q [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [CNT_W-1:0]  stamp_q [SETS][WAYS];

    logic [ADDR_W-1:0] pend_addr;
    logic [CNT_W-1:0]  pend_ref;
    logic [CNT_W-1:0]  ref_q;
    logic [CNT_W-1:0]  next_ref;

    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;

    logic [WAYS-1:0]            row_valid;
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic [WAYS-1:0][CNT_W-1:0] row_stamp;
    logic                       look_hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim;
    logic                       accept;
    logic                       fill;

    // address split: lookup uses the live request when idle, the held one while fetching
    assign look_addr = (state_q == ST_IDLE) ? req_addr : pend_addr;
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];

    generate
        if (IDX_BITS == 0) begin : g_one_set
            assign look_idx = '0;
        end else begin : g_many_sets
            assign look_idx = look_addr[2 +: IDX_BITS];
        end
    endgenerate

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_valid[w] = valid_q[look_idx][w];
            row_tag[w]   = tag_q[look_idx][w];
            row_stamp[w] = stamp_q[look_idx][w];
        end
    end

    wc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .row_valid (row_valid),
        .row_tag   (row_tag),
        .look_tag  (look_tag),
        .hit       (look_hit),
        .hit_way   (hit_way)
    );

    wc_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .row_valid (row_valid),
        .row_stamp (row_stamp),
        .victim    (victim)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign fill     = (state_q == ST_FETCH) && mem_ack;
    assign next_ref = ref_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && !look_hit) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack)             state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FETCH);
        mem_addr  = pend_addr;
    end

    // control registers, valid bits, response
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q      <= '0;
            pend_ref   <= '0;
            pend_addr  <= '0;
            hit_count  <= '0;
            miss_count <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_data   <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    valid_q[s][w] <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                ref_q <= next_ref;
                if (look_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_data  <= data_q[look_idx][hit_way];
                    hit_count <= hit_count + 1'b1;
                end else begin
                    pend_addr <= {req_addr[ADDR_W-1:2], 2'b00};
                    pend_ref  <= next_ref;
                end
            end
            if (fill) begin
                valid_q[look_idx][victim] <= 1'b1;
                rsp_valid  <= 1'b1;
                rsp_hit    <= 1'b0;
                rsp_data   <= mem_data;
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    // line payload and recency stamps
    always_ff @(posedge clk) begin
        if (accept && look_hit) begin
            stamp_q[look_idx][hit_way] <= next_ref;
        end
        if (fill) begin
            tag_q[look_idx][victim]   <= look_tag;
            data_q[look_idx][victim]  <= mem_data;
            stamp_q[look_idx][victim] <= pend_ref;
        end
    end

    // ---------------- assertions ----------------
    logic [WAYS-1:0] match_vec;
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            match_vec[w] = row_valid[w] && (row_tag[w] == look_tag);
    end

    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    assert_hit_reply_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && look_hit) |=> (rsp_valid && rsp_hit && req_ready));

    assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_busy_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_count_sum_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (CNT_W'(hit_count + miss_count) == ref_q));

    assert_count_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ($stable(hit_count) && $stable(miss_count)));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (hit_count == '0 && miss_count == '0 && !rsp_valid && !mem_req));
endmodule

// File: tb/wordcache_lru_tb.sv
`timescale 1ns/1ps
module wordcache_lru_tb;
    localparam int NDUT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;

    logic        rdy  [NDUT];
    logic        rv   [NDUT];
    logic        rh   [NDUT];
    logic [31:0] rd   [NDUT];
    logic        mr   [NDUT];
    logic [31:0] ma   [NDUT];
    logic        mack [NDUT];
    logic [31:0] md   [NDUT];
    logic [15:0] hc   [NDUT];
    logic [15:0] mc   [NDUT];

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    // instance 0: 2 sets x 2 ways; 1: direct-mapped 4x1; 2: fully associative 1x4
    wordcache_lru #(.ADDR_W(32), .DATA_W(32), .SETS(2), .WAYS(2), .CNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(rdy[0]),
        .rsp_valid(rv[0]), .rsp_data(rd[0]), .rsp_hit(rh[0]), .mem_req(mr[0]), .mem_addr(ma[0]),
        .mem_ack(mack[0]), .mem_data(md[0]), .hit_count(hc[0]), .miss_count(mc[0]));
    wordcache_lru #(.ADDR_W(32), .DATA_W(32), .SETS(4), .WAYS(1), .CNT_W(16)) u_dm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(rdy[1]),
        .rsp_valid(rv[1]), .rsp_data(rd[1]), .rsp_hit(rh[1]), .mem_req(mr[1]), .mem_addr(ma[1]),
        .mem_ack(mack[1]), .mem_data(md[1]), .hit_count(hc[1]), .miss_count(mc[1]));
    wordcache_lru #(.ADDR_W(32), .DATA_W(32), .SETS(1), .WAYS(4), .CNT_W(16)) u_fa (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(rdy[2]),
        .rsp_valid(rv[2]), .rsp_data(rd[2]), .rsp_hit(rh[2]), .mem_req(mr[2]), .mem_addr(ma[2]),
        .mem_ack(mack[2]), .mem_data(md[2]), .hit_count(hc[2]), .miss_count(mc[2]));

    function automatic logic [31:0] memf(logic [31:0] a);
        return ((a >> 2) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    // backing memory: acknowledge on the falling edge after a request is seen
    initial begin
        for (int k = 0; k < NDUT; k++) begin mack[k] = 1'b0; md[k] = '0; end
        forever begin
            @(negedge clk);
            for (int k = 0; k < NDUT; k++) begin
                mack[k] = mr[k] && !mack[k];
                md[k]   = memf(ma[k]);
            end
        end
    end

    // reference model of the requirements
    int          msets [NDUT] = '{2, 4, 1};
    int          mways [NDUT] = '{2, 1, 4};
    bit          mval  [NDUT][4][4];
    int unsigned mtag  [NDUT][4][4];
    int unsigned mst   [NDUT][4][4];
    int unsigned mref  [NDUT];
    int unsigned mhits [NDUT];

    function automatic void model_reset();
        for (int k = 0; k < NDUT; k++) begin
            mref[k] = 0; mhits[k] = 0;
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) begin
                    mval[k][s][w] = 0; mtag[k][s][w] = 0; mst[k][s][w] = 0;
                end
        end
    endfunction

    function automatic bit model_access(int k, logic [31:0] a);
        int unsigned wd = a >> 2;
        int s = wd % msets[k];
        int unsigned t = wd / msets[k];
        int v = -1;
        mref[k]++;
        for (int w = 0; w < mways[k]; w++)
            if (mval[k][s][w] && mtag[k][s][w] == t) begin
                mst[k][s][w] = mref[k]; mhits[k]++;
                return 1'b1;
            end
        for (int w = 0; w < mways[k]; w++)
            if (v < 0 && !mval[k][s][w]) v = w;
        if (v < 0) begin
            v = 0;
            for (int w = 1; w < mways[k]; w++)
                if (mst[k][s][w] < mst[k][s][v]) v = w;
        end
        mval[k][s][v] = 1; mtag[k][s][v] = t; mst[k][s][v] = mref[k];
        return 1'b0;
    endfunction

    task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic access(logic [31:0] a);
        bit exp [NDUT];
        bit done [NDUT];
        for (int k = 0; k < NDUT; k++) begin exp[k] = model_access(k, a); done[k] = 0; end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= 6; cyc++) begin
            for (int k = 0; k < NDUT; k++) begin
                if (cyc == 1 && !exp[k]) begin
                    check(mr[k] && !rdy[k], "R5 mem_req up and ready low", {30'b0, mr[k], rdy[k]}, 32'h2);
                    check(ma[k] == {a[31:2], 2'b00}, "R5 mem_addr aligned", ma[k], {a[31:2], 2'b00});
                end
                if (!done[k] && rv[k]) begin
                    done[k] = 1;
                    check(rh[k] == exp[k], "R3 R6 R7 R8 R11 hit flag", {31'b0, rh[k]}, {31'b0, exp[k]});
                    check(rd[k] == memf(a), "R1 R2 R4 R5 data", rd[k], memf(a));
                    check(cyc == (exp[k] ? 1 : 2), "R4 R5 latency", cyc, exp[k] ? 1 : 2);
                    if (exp[k]) check(rdy[k], "R4 ready kept", {31'b0, rdy[k]}, 1);
                end
            end
            if (done[0] && done[1] && done[2]) break;
            @(negedge clk);
        end
        for (int k = 0; k < NDUT; k++)
            if (!done[k]) check(1'b0, "R4 R5 no response", 0, 1);
    endtask

    task automatic check_counts();
        for (int k = 0; k < NDUT; k++) begin
            check(hc[k] == 16'(mhits[k]), "R9 hit_count", hc[k], mhits[k]);
            check(32'(hc[k]) + 32'(mc[k]) == mref[k], "R9 count sum", 32'(hc[k]) + 32'(mc[k]), mref[k]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        for (int k = 0; k < NDUT; k++) begin
            check(rdy[k] && !rv[k] && !mr[k], "R10 idle after reset", {29'b0, rdy[k], rv[k], mr[k]}, 32'h4);
            check(hc[k] == 0 && mc[k] == 0, "R10 counts cleared", {hc[k], mc[k]}, 0);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset();

        // R3 R11: 0,4,0,4 word stream, first access to address 0 misses
        access(32'h0); access(32'h10); access(32'h0); access(32'h10);
        check(hc[0] == 2, "R11 two-way hits", hc[0], 2);
        check(hc[1] == 0, "R11 direct-mapped hits", hc[1], 0);
        check(hc[2] == 2, "R11 fully associative hits", hc[2], 2);
        // R1: other byte offsets of a cached word
        access(32'h3); access(32'h11);
        check(hc[2] == 4, "R1 byte offset ignored", hc[2], 4);

        // R6 R7 R8: fill the fully associative set, age way of word 2, evict it
        do_reset();
        for (int i = 0; i < 4; i++) access(32'(i * 4));
        access(32'h4); access(32'h0); access(32'hC);
        access(32'h14);
        access(32'h0); access(32'h4); access(32'hC); access(32'h14);
        check(hc[2] == 7, "R7 oldest evicted", hc[2], 7);
        access(32'h8);
        check(mc[2] == 6, "R7 evicted word misses", mc[2], 6);
        check_counts();

        // R2: same set, tag differs only in high bits
        access(32'h0010_0000); access(32'h0);
        check_counts();

        // sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {lfsr[15] ? 12'h001 : 12'h000, 12'h000, 2'b00, lfsr[3:0], lfsr[9:8]};
            access(a);
        end
        check_counts();

        // R10: reset mid-run invalidates everything
        do_reset();
        access(32'h0); access(32'h4);
        check(mc[0] == 2 && hc[0] == 0, "R10 R3 cold after reset", {hc[0], mc[0]}, 2);
        check_counts();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule